// File: doc/BRIEF.md
# Multi-Layer Associative Pattern Matcher

The block keeps a bank of preloaded track patterns. Every pattern holds one coarse super-strip word for each detector layer. During an event a stream of (layer, super-strip) words arrives. Each word is compared in a single cycle against that layer's word in every stored pattern. Every pattern that agrees records a per-layer flag. The flags persist until the event is over, so a pattern gathers evidence from the whole stream rather than from one lookup.

When the end-of-event strobe arrives, each pattern whose count of set layer flags reaches a programmable threshold becomes a road. The pattern addresses of the roads are streamed out in ascending order on a valid/ready interface, and the final road carries a last flag. A pattern address also indexes a separate copy of the bank, so a later stage can recover the super-strips of a road. After the readout finishes, all flags are cleared for the next event. Patterns are written one layer word at a time through a load port before data taking.

Top module: `road_finder`

## Requirements
- R1: After reset `road_valid` is low, every layer flag is clear, and an event with threshold 1 and no input words yields no road.
- R2: A cycle with `load_en` high writes `load_word` into layer `load_layer` of pattern `load_pat`. Later input words are compared against the new content.
- R3: An accepted input word (`in_valid` high while no readout runs) sets layer flag `in_layer` of every pattern whose word for that layer equals `in_word`. It sets no flag of any other layer or pattern.
- R4: Repeating a word on the same layer sets that pattern's layer flag only once, so it adds at most one to the layer count.
- R5: A pattern becomes a road exactly when its number of set layer flags is at least `thresh`, sampled in the cycle of `eoe`. A threshold of 0 makes every pattern a road, and a threshold above the layer count makes none.
- R6: Roads appear in strictly ascending pattern-address order. The first road is valid in the cycle after `eoe` is sampled. One road retires per cycle in which `road_valid` and `road_ready` are both high, and `road_addr` and `road_last` hold while `road_ready` is low.
- R7: `road_last` is high on the final road of an event and low on every other road.
- R8: Input words and `eoe` presented during a readout are ignored. All flags are cleared when the readout ends, so the next event starts with no flags set.
- R9: A word presented in the same cycle as `eoe` is counted toward that event.
- R10: An event with no road raises `road_valid` at no point, and the block is ready for a new event two cycles after `eoe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write one layer word of one pattern |
| load_pat | input | PAT_W (6) | Pattern address to write |
| load_layer | input | LAY_W (3) | Layer to write |
| load_word | input | WORD_W (16) | Super-strip word to store |
| thresh | input | CNT_W (4) | Minimum number of matched layers for a road |
| in_valid | input | 1 | Input word present |
| in_layer | input | LAY_W (3) | Layer of the input word |
| in_word | input | WORD_W (16) | Coarse super-strip value |
| eoe | input | 1 | End-of-event strobe |
| road_valid | output | 1 | A road is presented |
| road_ready | input | 1 | Consumer accepts the road |
| road_addr | output | PAT_W (6) | Pattern address of the road |
| road_last | output | 1 | Final road of the event |

## Verification
A word takes effect at the clock edge that samples it, and the roads of an event are captured at the edge that samples `eoe`. The first road is therefore due at the first falling edge after that capture, and the bench checks `road_valid` exactly there. Later roads are compared only at falling edges where the bench itself holds `road_ready` high, so each comparison matches one retiring handshake. Because flags are cleared one edge after the last road retires, the bench waits four idle cycles before each new event and checks during that window that no further road appears.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_READ = 1'b1
    } scan_st_e;

endpackage

// File: rtl/pm_bank.sv
module pm_bank #(
    parameter int NUM_PAT    = 64,
    parameter int NUM_LAYERS = 8,
    parameter int WORD_W     = 16,
    localparam int PAT_W     = $clog2(NUM_PAT),
    localparam int LAY_W     = $clog2(NUM_LAYERS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [PAT_W-1:0]   wr_pat_i,
    input  logic [LAY_W-1:0]   wr_layer_i,
    input  logic [WORD_W-1:0]  wr_word_i,
    input  logic [LAY_W-1:0]   cmp_layer_i,
    input  logic [WORD_W-1:0]  cmp_word_i,
    output logic [NUM_PAT-1:0] hit_o
);

    typedef struct packed {
        logic [NUM_PAT-1:0][NUM_LAYERS-1:0][WORD_W-1:0] mem;
    } bank_s;

    bank_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en_i && (int'(wr_pat_i) < NUM_PAT) && (int'(wr_layer_i) < NUM_LAYERS)) begin
            s_d.mem[wr_pat_i][wr_layer_i] = wr_word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // One comparator per pattern, all driven by the same layer selector.
    for (genvar p = 0; p < NUM_PAT; p++) begin : g_cmp
        assign hit_o[p] = (int'(cmp_layer_i) < NUM_LAYERS) &&
                          (s_q.mem[p][cmp_layer_i] == cmp_word_i);
    end

endmodule

// File: rtl/pm_flags.sv
module pm_flags #(
    parameter int NUM_PAT    = 64,
    parameter int NUM_LAYERS = 8,
    localparam int LAY_W     = $clog2(NUM_LAYERS),
    localparam int CNT_W     = $clog2(NUM_LAYERS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en_i,
    input  logic [LAY_W-1:0]   set_layer_i,
    input  logic [NUM_PAT-1:0] hit_i,
    input  logic               clear_i,
    input  logic [CNT_W-1:0]   thresh_i,
    output logic [NUM_PAT-1:0] match_nxt_o
);

    typedef struct packed {
        logic [NUM_PAT-1:0][NUM_LAYERS-1:0] flg;
    } flags_s;

    flags_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.flg = '0;
        end else if (set_en_i && (int'(set_layer_i) < NUM_LAYERS)) begin
            for (int p = 0; p < NUM_PAT; p++) begin
                if (hit_i[p]) begin
                    s_d.flg[p][set_layer_i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Per-pattern layer counter on the next-state flags, so a word that
    // arrives together with the end-of-event strobe is included.
    for (genvar p = 0; p < NUM_PAT; p++) begin : g_cnt
        logic [CNT_W-1:0] cnt;
        always_comb begin
            cnt = '0;
            for (int l = 0; l < NUM_LAYERS; l++) begin
                cnt = cnt + CNT_W'(s_d.flg[p][l]);
            end
        end
        assign match_nxt_o[p] = (cnt >= thresh_i);
    end

    // No new flag appears unless a word was accepted.
    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !set_en_i |=> ((s_q.flg & ~$past(s_q.flg)) == '0));

    // Flags only accumulate between clears, so repeats cannot add twice.
    assert_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((s_q.flg & $past(s_q.flg)) == $past(s_q.flg)));

    assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (s_q.flg == '0));

endmodule

// File: rtl/pm_scan.sv
module pm_scan
    import pm_pkg::*;
#(
    parameter int NUM_PAT = 64,
    localparam int PAT_W  = $clog2(NUM_PAT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eoe_i,
    input  logic [NUM_PAT-1:0] match_nxt_i,
    input  logic               ready_i,
    output logic               valid_o,
    output logic [PAT_W-1:0]   addr_o,
    output logic               last_o,
    output logic               busy_o,
    output logic               clear_o
);

    typedef struct packed {
        scan_st_e           st;
        logic [NUM_PAT-1:0] pend;
    } scan_s;

    scan_s s_d, s_q;

    logic [PAT_W-1:0]   first_idx;
    logic [NUM_PAT-1:0] first_oh;

    // Lowest pending pattern wins: scan from the top down.
    always_comb begin
        first_idx = '0;
        for (int i = NUM_PAT - 1; i >= 0; i--) begin
            if (s_q.pend[i]) begin
                first_idx = PAT_W'(i);
            end
        end
        first_oh = NUM_PAT'(1) << first_idx;
    end

    always_comb begin
        s_d     = s_q;
        clear_o = 1'b0;
        case (s_q.st)
            SCAN_IDLE: begin
                if (eoe_i) begin
                    s_d.pend = match_nxt_i;
                    s_d.st   = SCAN_READ;
                end
            end
            SCAN_READ: begin
                if (s_q.pend == '0) begin
                    clear_o = 1'b1;
                    s_d.st  = SCAN_IDLE;
                end else if (ready_i) begin
                    s_d.pend = s_q.pend & ~first_oh;
                end
            end
            default: s_d.st = SCAN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SCAN_IDLE, pend: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o  = (s_q.st == SCAN_READ);
    assign valid_o = busy_o && (s_q.pend != '0);
    assign addr_o  = first_idx;
    assign last_o  = valid_o && ((s_q.pend & ~first_oh) == '0);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(last_o)));

    assert_ascend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i) |=> (!valid_o || (addr_o > $past(addr_o))));

endmodule

// File: rtl/road_finder.sv
module road_finder #(
    parameter int NUM_PAT    = 64,
    parameter int NUM_LAYERS = 8,
    parameter int WORD_W     = 16,
    localparam int PAT_W     = $clog2(NUM_PAT),
    localparam int LAY_W     = $clog2(NUM_LAYERS),
    localparam int CNT_W     = $clog2(NUM_LAYERS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [PAT_W-1:0]  load_pat,
    input  logic [LAY_W-1:0]  load_layer,
    input  logic [WORD_W-1:0] load_word,
    input  logic [CNT_W-1:0]  thresh,
    input  logic              in_valid,
    input  logic [LAY_W-1:0]  in_layer,
    input  logic [WORD_W-1:0] in_word,
    input  logic              eoe,
    output logic              road_valid,
    input  logic              road_ready,
    output logic [PAT_W-1:0]  road_addr,
    output logic              road_last
);

    logic [NUM_PAT-1:0] hit;
    logic [NUM_PAT-1:0] match_nxt;
    logic               busy;
    logic               clear_flags;
    logic               accept;

    assign accept = in_valid && !busy;

    pm_bank #(
        .NUM_PAT   (NUM_PAT),
        .NUM_LAYERS(NUM_LAYERS),
        .WORD_W    (WORD_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (load_en),
        .wr_pat_i   (load_pat),
        .wr_layer_i (load_layer),
        .wr_word_i  (load_word),
        .cmp_layer_i(in_layer),
        .cmp_word_i (in_word),
        .hit_o      (hit)
    );

    pm_flags #(
        .NUM_PAT   (NUM_PAT),
        .NUM_LAYERS(NUM_LAYERS)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en_i   (accept),
        .set_layer_i(in_layer),
        .hit_i      (hit),
        .clear_i    (clear_flags),
        .thresh_i   (thresh),
        .match_nxt_o(match_nxt)
    );

    pm_scan #(
        .NUM_PAT(NUM_PAT)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .eoe_i      (eoe),
        .match_nxt_i(match_nxt),
        .ready_i    (road_ready),
        .valid_o    (road_valid),
        .addr_o     (road_addr),
        .last_o     (road_last),
        .busy_o     (busy),
        .clear_o    (clear_flags)
    );

    // A readout can only begin on an end-of-event strobe.
    assert_start_after_eoe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(road_valid) |-> $past(eoe));

    // Retiring the flagged final road ends the stream.
    assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (road_valid && road_ready && road_last) |=> !road_valid);

endmodule

// File: tb/road_finder_tb.sv
module road_finder_tb;

    localparam int NP = 64;
    localparam int NL = 8;
    localparam int WW = 16;
    localparam int PW = 6;
    localparam int LW = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          load_en;
    logic [PW-1:0] load_pat;
    logic [LW-1:0] load_layer;
    logic [WW-1:0] load_word;
    logic [CW-1:0] thresh;
    logic          in_valid;
    logic [LW-1:0] in_layer;
    logic [WW-1:0] in_word;
    logic          eoe;
    logic          road_valid;
    logic          road_ready;
    logic [PW-1:0] road_addr;
    logic          road_last;

    always #10 clk = ~clk;

    road_finder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_pat  (load_pat),
        .load_layer(load_layer),
        .load_word (load_word),
        .thresh    (thresh),
        .in_valid  (in_valid),
        .in_layer  (in_layer),
        .in_word   (in_word),
        .eoe       (eoe),
        .road_valid(road_valid),
        .road_ready(road_ready),
        .road_addr (road_addr),
        .road_last (road_last)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Bench model: pattern contents and per-pattern layer flags.
    logic [WW-1:0] pm [NP][NL];
    logic [NL-1:0] ef [NP];
    int            ex [NP];
    int            ex_n;

    function automatic logic [WW-1:0] pat_word(int p, int l);
        return WW'(l * 256 + p / (1 + l % 4));
    endfunction

    task automatic check_eq(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_one(int p, int l, logic [WW-1:0] w);
        load_en = 1'b1; load_pat = PW'(p); load_layer = LW'(l); load_word = w;
        @(negedge clk);
        load_en = 1'b0;
        pm[p][l] = w;
    endtask

    task automatic model_word(int l, logic [WW-1:0] w);
        for (int p = 0; p < NP; p++)
            if (pm[p][l] == w) ef[p][l] = 1'b1;
    endtask

    task automatic send(int l, logic [WW-1:0] w);
        in_valid = 1'b1; in_layer = LW'(l); in_word = w;
        @(negedge clk);
        in_valid = 1'b0;
        model_word(l, w);
    endtask

    function automatic bit ready_rule(int mode, int cyc);
        case (mode)
            1: return (cyc % 3) != 1;
            2: return (cyc % 4) >= 2;
            default: return 1'b1;
        endcase
    endfunction

    // Ends an event and collects its roads against the model.
    task automatic run_event(string req, int thr, int rmode, bit with_word,
                             int wl, logic [WW-1:0] ww, bit inject);
        int k;
        int idle;
        if (with_word) model_word(wl, ww);  // R9: word with eoe counts
        ex_n = 0;
        for (int p = 0; p < NP; p++)
            if ($countones(ef[p]) >= thr) begin ex[ex_n] = p; ex_n++; end
        eoe = 1'b1; thresh = CW'(thr);
        if (with_word) begin in_valid = 1'b1; in_layer = LW'(wl); in_word = ww; end
        @(negedge clk);
        eoe = 1'b0; in_valid = 1'b0;
        for (int p = 0; p < NP; p++) ef[p] = '0;
        k = 0; idle = 0;
        for (int cyc = 0; cyc < 1000; cyc++) begin
            road_ready = ready_rule(rmode, cyc);
            if (inject && cyc == 0) begin
                // R8: word and eoe during readout must be ignored
                in_valid = 1'b1; in_layer = '0; in_word = pm[0][0]; eoe = 1'b1;
            end else begin
                in_valid = 1'b0; eoe = 1'b0;
            end
            if (cyc == 0) check_eq({req, " R6 first road timing"}, int'(road_valid), int'(ex_n > 0));
            if (k < ex_n) begin
                if (road_valid && road_ready) begin
                    check_eq({req, " R6 road order"}, int'(road_addr), ex[k]);
                    check_eq({req, " R7 last flag"}, int'(road_last), int'(k == ex_n - 1));
                    k++;
                end
            end else begin
                check_eq({req, " R10 no extra road"}, int'(road_valid), 0);
                idle++;
            end
            @(negedge clk);
            if (idle >= 4) break;
        end
        road_ready = 1'b0; in_valid = 1'b0; eoe = 1'b0;
        check_eq({req, " R6 road count"}, k, ex_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; load_en = 1'b0; load_pat = '0; load_layer = '0; load_word = '0;
        thresh = '0; in_valid = 1'b0; in_layer = '0; in_word = '0; eoe = 1'b0;
        road_ready = 1'b0;
        for (int p = 0; p < NP; p++) ef[p] = '0;
        for (int p = 0; p < NP; p++)
            for (int l = 0; l < NL; l++) pm[p][l] = '0;
        repeat (5) @(negedge clk);
        check_eq("R1 reset valid", int'(road_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 valid after reset", int'(road_valid), 0);

        // R2: load the whole bank
        for (int p = 0; p < NP; p++)
            for (int l = 0; l < NL; l++) load_one(p, l, pat_word(p, l));

        // R1: flags start clear
        run_event("R1 empty", 1, 0, 0, 0, '0, 0);

        // R3: full match of one pattern
        for (int l = 0; l < NL; l++) send(l, pm[5][l]);
        run_event("R3 full match", 8, 0, 0, 0, '0, 0);

        // R5: partial match at and below threshold
        for (int l = 0; l < 6; l++) send(l, pm[10][l]);
        run_event("R5 thr6", 6, 1, 0, 0, '0, 0);
        for (int l = 0; l < 6; l++) send(l, pm[10][l]);
        run_event("R5 thr7", 7, 1, 0, 0, '0, 0);

        // R4: repeated words count once
        send(0, pm[20][0]); send(0, pm[20][0]); send(0, pm[20][0]); send(1, pm[20][1]);
        run_event("R4 repeat", 3, 0, 0, 0, '0, 0);
        send(0, pm[20][0]); send(0, pm[20][0]); send(1, pm[20][1]);
        run_event("R4 repeat thr2", 2, 2, 0, 0, '0, 0);

        // R9: final word alongside eoe
        for (int l = 0; l < 7; l++) send(l, pm[33][l]);
        run_event("R9 same cycle", 8, 0, 1, 7, pm[33][7], 0);

        // R2: rewrite pattern 63 and match the new content
        for (int l = 0; l < NL; l++) load_one(63, l, WW'(16'hF000 + l));
        for (int l = 0; l < NL; l++) send(l, pm[63][l]);
        run_event("R2 reload", 8, 1, 0, 0, '0, 0);

        // R8: threshold 0 gives every pattern, with backpressure and injection
        run_event("R8 thr0 inject", 0, 2, 0, 0, '0, 1);
        run_event("R8 after readout", 1, 0, 0, 0, '0, 0);

        // R5: threshold sweep over a scattered word set
        for (int thr = 0; thr <= 9; thr++) begin
            for (int k = 0; k < 40; k++) send(k % NL, pm[(k * 37 + 11) % NP][k % NL]);
            run_event("R5 sweep", thr, thr % 3, 0, 0, '0, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule